// File: doc/BRIEF.md
# Half-duplex three-wire serial master

The block drives a serial bus that uses a single bidirectional data wire, a serial clock and an active-low chip select. A transaction is one write phase followed by one read phase. The host loads two bit counts (each holding the bit total minus one) and a half-period divider, then pulses `start`. The master lowers chip select and shifts out the write bits, most significant bit first. It takes 32-bit words from a valid/ready word input, fetching a new word every 32 bits. After the last write bit it releases the data wire with the clock low and adds one extra clock-high interval as a bus turnaround. It then samples the read bits and hands each completed 32-bit word out on a valid/ready word output.

When the read phase is over, the master holds the clock low until the device pulls the data wire high. It then raises chip select, returns to idle and pulses a one-cycle completion event. A typical register write sends N×32 bits and reads back one 32-bit status word. A typical register read sends one 32-bit command and reads N×32 data bits plus a status word.

The data wire is brought out as an output value, an output enable and an input. The pad is expected to provide a weak pull-down while the wire is released.

Top module: `tw_spi_master`

## Requirements
- R1: After reset, `cs_n` is 1, `sclk` is 0, `sdio_oe` is 1 with `sdio_o` 0, and `busy`, `tx_ready`, `rx_valid` and `done_pulse` are 0.
- R2: The write phase puts exactly `wr_bits`+1 bits on `sdio_o`, MSB first. Bit i is bit 31-(i mod 32) of the word taken in handshake number i/32. A word is taken only when a new one is needed, so the transaction takes ceil((`wr_bits`+1)/32) words.
- R3: Each write bit is presented while `sclk` is low and held unchanged with `sdio_oe` high for the whole following high interval.
- R4: After the last write bit, `sdio_oe` falls while `sclk` is low. The next rising edge of `sclk` comes 2×`half_div` cycles after the last write rising edge, and it opens one extended high interval (two half periods) at whose end the first read bit is sampled.
- R5: The read phase samples `rd_bits`+1 bits from `sdio_i`, each at the end of a high interval, MSB first. Every completed group of 32 is offered on `rx_word`/`rx_valid`. A trailing group of fewer than 32 bits is not delivered. The whole transaction shows `wr_bits`+`rd_bits`+2 rising edges of `sclk`.
- R6: Each half period of `sclk` lasts `half_div` system clock cycles (a value of 0 acts as 1), so the serial clock runs at the system clock divided by 2×`half_div`.
- R7: `tx_ready` is high only while a word is needed in the write phase. While it waits for `tx_valid`, `sclk` stays low. When a word is offered at once, a word boundary adds exactly one cycle to the bit period.
- R8: While a received word is not yet accepted, `sclk` does not rise and no further bit is sampled. When `rx_ready` is already high, accepting the word adds no cycles to the bit period.
- R9: After the last read bit, `sclk` stays low and `busy` stays high until `sdio_i` is 1. One cycle later `done_pulse` is high for exactly one cycle, together with `cs_n` 1 and `busy` 0.
- R10: `cs_n` is low and `busy` high from the cycle after an accepted `start` until the `done_pulse` cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| half_div | input | DIV_W | Half period of the serial clock in system cycles |
| wr_bits | input | CNT_W | Write bit total minus one, loaded at start |
| rd_bits | input | CNT_W | Read bit total minus one, loaded at start |
| start | input | 1 | Starts a transaction when idle |
| busy | output | 1 | Transaction in progress |
| tx_word | input | WORD_W | Word to transmit |
| tx_valid | input | 1 | `tx_word` is valid |
| tx_ready | output | 1 | Master takes `tx_word` this cycle if valid |
| rx_word | output | WORD_W | Received word |
| rx_valid | output | 1 | `rx_word` is valid |
| rx_ready | input | 1 | Host accepts `rx_word` |
| done_pulse | output | 1 | One-cycle completion event |
| sclk | output | 1 | Serial clock |
| cs_n | output | 1 | Active-low chip select |
| sdio_o | output | 1 | Data wire output value |
| sdio_oe | output | 1 | Data wire output enable |
| sdio_i | input | 1 | Data wire input |

## Verification
Two events can land in the same cycle. One is the host accepting a completed read word; the other is the expiry of the low half period that must wait for that acceptance. With a half period of one cycle and `rx_ready` held high, both fall in the single low cycle after the 32nd sample. The bench sets up that case with several bit counts and checks the rising-edge spacing at each read word boundary, which must stay at exactly two cycles. Write word boundaries are handled in a similar way: there the bench checks that a word offered at once costs exactly one extra cycle.

// File: rtl/tws_pkg.sv
package tws_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WLO,
    ST_WHI,
    ST_TLO,
    ST_THI,
    ST_RHI,
    ST_RLO,
    ST_WAIT
  } tws_state_t;

  // Serial clock level that belongs to a state.
  function automatic logic clk_level(input tws_state_t s);
    return (s == ST_WHI) || (s == ST_THI) || (s == ST_RHI);
  endfunction

endpackage

// File: rtl/tws_half_timer.sv
module tws_half_timer #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reload,
  input  logic [DIV_W-1:0] half,
  output logic             done
);

  // Last count of a half period; zero is treated as one cycle.
  function automatic logic [DIV_W-1:0] last_tick(input logic [DIV_W-1:0] h);
    return (h == '0) ? '0 : h - 1'b1;
  endfunction

  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (reload)         cnt_q <= last_tick(half);
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);

endmodule

// File: rtl/tws_tx_shift.sv
module tws_tx_shift #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              load,
  input  logic              shift,
  input  logic [WORD_W-1:0] word,
  output logic              bit_o,
  output logic              need_word
);

  localparam int LEFT_W = $clog2(WORD_W + 1);

  logic [WORD_W-1:0] sh_q;
  logic [LEFT_W-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      left_q <= '0;
    end else if (clr) begin
      left_q <= '0;
    end else if (load) begin
      sh_q   <= word;
      left_q <= LEFT_W'(WORD_W);
    end else if (shift) begin
      sh_q   <= {sh_q[WORD_W-2:0], 1'b0};
      left_q <= left_q - 1'b1;
    end
  end

  assign need_word = (left_q == '0);
  assign bit_o     = sh_q[WORD_W-1];

  // A word is only taken once the previous one is used up.
  assert_load_when_empty_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> need_word);

  // No shift past the end of a word.
  assert_shift_has_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    shift |-> !need_word);

endmodule

// File: rtl/tws_rx_shift.sv
module tws_rx_shift #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              sample,
  input  logic              bit_i,
  input  logic              rx_ready,
  output logic [WORD_W-1:0] rx_word,
  output logic              rx_valid
);

  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic [WORD_W-2:0] sh_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              word_done;

  assign word_done = sample && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q    <= '0;
      cnt_q   <= '0;
      rx_word <= '0;
    end else if (clr) begin
      cnt_q <= '0;
    end else if (sample) begin
      sh_q <= {sh_q[WORD_W-3:0], bit_i};
      if (word_done) begin
        rx_word <= {sh_q, bit_i};
        cnt_q   <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         rx_valid <= 1'b0;
    else if (word_done) rx_valid <= 1'b1;
    else if (rx_ready)  rx_valid <= 1'b0;
  end

  // A pending word is never overwritten: sampling waits for acceptance.
  assert_no_overrun_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sample |-> !rx_valid);

endmodule

// File: rtl/tw_spi_master.sv
module tw_spi_master
  import tws_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int CNT_W  = 12,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  half_div,
  input  logic [CNT_W-1:0]  wr_bits,
  input  logic [CNT_W-1:0]  rd_bits,
  input  logic              start,
  output logic              busy,
  input  logic [WORD_W-1:0] tx_word,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic [WORD_W-1:0] rx_word,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic              done_pulse,
  output logic              sclk,
  output logic              cs_n,
  output logic              sdio_o,
  output logic              sdio_oe,
  input  logic              sdio_i
);

  tws_state_t       state_q, state_d;
  logic [CNT_W-1:0] wleft_q, rleft_q;
  logic             t_done, need_word, tx_bit;
  logic             sclk_q, cs_q, oe_q, done_q;

  // Named internal events.
  logic accept_start, tx_take, shift_now, sample_now, rx_free, rlo_exit, wait_hit;
  logic reload;

  assign accept_start = (state_q == ST_IDLE) && start;
  assign tx_ready     = (state_q == ST_WLO) && need_word;
  assign tx_take      = tx_ready && tx_valid;
  assign shift_now    = (state_q == ST_WHI) && t_done;
  assign sample_now   = (state_q == ST_RHI) && t_done;
  assign rx_free      = !rx_valid || rx_ready;
  assign rlo_exit     = (state_q == ST_RLO) && t_done && rx_free;
  assign wait_hit     = (state_q == ST_WAIT) && sdio_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start)                state_d = ST_WLO;
      ST_WLO:  if (!need_word && t_done) state_d = ST_WHI;
      ST_WHI:  if (t_done)               state_d = (wleft_q == '0) ? ST_TLO : ST_WLO;
      ST_TLO:  if (t_done)               state_d = ST_THI;
      ST_THI:  if (t_done)               state_d = ST_RHI;
      ST_RHI:  if (t_done)               state_d = ST_RLO;
      ST_RLO:  if (rlo_exit)             state_d = (rleft_q == '0) ? ST_WAIT : ST_RHI;
      ST_WAIT: if (sdio_i)               state_d = ST_IDLE;
      default:                           state_d = ST_IDLE;
    endcase
  end

  assign reload = (state_d != state_q) || tx_take;

  tws_half_timer #(.DIV_W(DIV_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .reload (reload),
    .half   (half_div),
    .done   (t_done)
  );

  tws_tx_shift #(.WORD_W(WORD_W)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (accept_start),
    .load      (tx_take),
    .shift     (shift_now),
    .word      (tx_word),
    .bit_o     (tx_bit),
    .need_word (need_word)
  );

  tws_rx_shift #(.WORD_W(WORD_W)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (accept_start),
    .sample   (sample_now),
    .bit_i    (sdio_i),
    .rx_ready (rx_ready),
    .rx_word  (rx_word),
    .rx_valid (rx_valid)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sclk_q  <= 1'b0;
      cs_q    <= 1'b1;
      oe_q    <= 1'b1;
      done_q  <= 1'b0;
      wleft_q <= '0;
      rleft_q <= '0;
    end else begin
      state_q <= state_d;
      sclk_q  <= clk_level(state_d);
      done_q  <= wait_hit;
      if (accept_start) begin
        wleft_q <= wr_bits;
        rleft_q <= rd_bits;
        cs_q    <= 1'b0;
        oe_q    <= 1'b1;
      end else begin
        if (wait_hit) cs_q <= 1'b1;
        if (shift_now) begin
          if (wleft_q != '0) wleft_q <= wleft_q - 1'b1;
          else               oe_q    <= 1'b0;
        end
        if (rlo_exit && rleft_q != '0) rleft_q <= rleft_q - 1'b1;
      end
    end
  end

  assign busy       = (state_q != ST_IDLE);
  assign sclk       = sclk_q;
  assign cs_n       = cs_q;
  assign sdio_oe    = oe_q;
  assign done_pulse = done_q;
  assign sdio_o     = ((state_q == ST_WLO) || (state_q == ST_WHI)) ? tx_bit : 1'b0;

  assert_tx_stall_clock_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ready && !tx_valid) |=> !sclk);

  assert_rx_stall_no_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> !$rose(sclk));

  assert_data_held_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk) && sdio_oe) |-> $stable(sdio_o));

  assert_release_clock_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sdio_oe) |-> !sclk);

  assert_event_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |=> !done_pulse);

  assert_event_closes_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |-> (cs_n && !busy));

  assert_cs_while_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cs_n);

endmodule

// File: tb/tw_spi_master_test.sv
module tw_spi_master_test;

  localparam int WORD_W = 32;
  localparam int CNT_W  = 12;
  localparam int DIV_W  = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [DIV_W-1:0]  half_div = 8'd1;
  logic [CNT_W-1:0]  wr_bits = '0;
  logic [CNT_W-1:0]  rd_bits = '0;
  logic              start = 1'b0;
  logic              busy;
  logic [WORD_W-1:0] tx_word = '0;
  logic              tx_valid = 1'b0;
  logic              tx_ready;
  logic [WORD_W-1:0] rx_word;
  logic              rx_valid;
  logic              rx_ready = 1'b0;
  logic              done_pulse;
  logic              sclk, cs_n, sdio_o, sdio_oe;
  logic              dev_en = 1'b0;
  logic              dev_bit = 1'b0;
  logic              line;

  // Wire resolution with a weak pull-down when nobody drives.
  assign line = sdio_oe ? sdio_o : (dev_en ? dev_bit : 1'b0);

  always #10 clk = ~clk;

  tw_spi_master #(.WORD_W(WORD_W), .CNT_W(CNT_W), .DIV_W(DIV_W)) uut (
    .clk(clk), .rst_n(rst_n), .half_div(half_div), .wr_bits(wr_bits), .rd_bits(rd_bits),
    .start(start), .busy(busy), .tx_word(tx_word), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_word(rx_word), .rx_valid(rx_valid), .rx_ready(rx_ready), .done_pulse(done_pulse),
    .sclk(sclk), .cs_n(cs_n), .sdio_o(sdio_o), .sdio_oe(sdio_oe), .sdio_i(line)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit hung     = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] txw(input int k, input int seed);
    return (32'(k + 1) * 32'h9E3779B1) ^ (32'(seed) * 32'h85EBCA6B) ^ 32'h3C5A96E1;
  endfunction

  function automatic logic txbit(input int i, input int seed);
    logic [31:0] w;
    w = txw(i / 32, seed);
    return w[31 - (i % 32)];
  endfunction

  function automatic logic rdpat(input int j, input int seed);
    logic [31:0] v;
    v = 32'(j + seed * 13 + 1) * 32'h2545F491;
    return v[31] ^ v[17] ^ v[5];
  endfunction

  function automatic logic [31:0] rxw(input int k, input int seed);
    logic [31:0] w;
    for (int b = 0; b < 32; b++) w[31 - b] = rdpat(32 * k + b, seed);
    return w;
  endfunction

  task automatic run_txn(input int hd, input int W, input int R,
                         input int txd, input int rxd, input int wdel, input int seed);
    int ntx, nrx, tx_idx, rx_idx, tx_hold, rx_hold;
    int rises, cyc, last_rise, wctr, guard, csbad, j, iv;
    bit sp, rising, falling, tx_pend, rx_pend, wait_arm, raised, finished;
    ntx = (W + 31) / 32;
    nrx = R / 32;
    tx_idx = 0; rx_idx = 0; tx_hold = txd; rx_hold = rxd;
    rises = 0; cyc = 0; last_rise = 0; wctr = 0; guard = 0; csbad = 0;
    sp = 1'b0; tx_pend = 1'b0; rx_pend = 1'b0;
    wait_arm = 1'b0; raised = 1'b0; finished = 1'b0;
    @(negedge clk);
    half_div = DIV_W'(hd);
    wr_bits  = CNT_W'(W - 1);
    rd_bits  = CNT_W'(R - 1);
    rx_ready = (rxd == 0);
    start    = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(!cs_n && busy, "R10", "cs_n low and busy after start", {cs_n, busy}, 2'b01);
    while (!finished && guard < 30000) begin
      guard++;
      rising  = sclk && !sp;
      falling = !sclk && sp;
      sp      = sclk;
      if (rising) begin
        rises++;
        if (rises <= W) begin
          chk(sdio_oe && sdio_o == txbit(rises - 1, seed), "R2", "write bit value",
              {sdio_oe, sdio_o}, {1'b1, txbit(rises - 1, seed)});
          if (rises >= 2) begin
            iv = cyc - last_rise;
            if ((rises - 1) % 32 != 0)
              chk(iv == 2 * hd, "R6", "write bit period", iv, 2 * hd);
            else if (txd == 0)
              chk(iv == 2 * hd + 1, "R7", "write word boundary period", iv, 2 * hd + 1);
          end
        end else begin
          j = rises - W - 1;
          if (j == 0) begin
            chk(!sdio_oe, "R4", "wire released at turnaround", sdio_oe, 0);
            chk(cyc - last_rise == 2 * hd, "R4", "turnaround edge spacing",
                cyc - last_rise, 2 * hd);
            dev_en = 1'b1;
          end else if (rxd == 0) begin
            iv  = cyc - last_rise;
            chk(iv == ((j == 1) ? 3 * hd : 2 * hd), "R8", "read bit period",
                iv, (j == 1) ? 3 * hd : 2 * hd);
          end
          dev_bit = rdpat(j, seed);
        end
        last_rise = cyc;
      end
      if (falling && rises == W + R && !wait_arm) begin
        wait_arm = 1'b1;
        dev_en   = 1'b0;
        wctr     = wdel;
      end else if (wait_arm && !raised) begin
        if (wctr == 0) begin
          chk(!sclk && busy && !done_pulse, "R9", "clock low and busy while waiting",
              {sclk, busy, done_pulse}, 3'b010);
          raised  = 1'b1;
          dev_en  = 1'b1;
          dev_bit = 1'b1;
        end else wctr--;
      end
      if (done_pulse) begin
        finished = 1'b1;
        chk(raised, "R9", "event only after wire high", raised, 1);
        chk(cs_n && !busy && !sclk, "R9", "cs_n high, idle, clock low at event",
            {cs_n, busy, sclk}, 3'b100);
        chk(rises == W + R, "R5", "rising edge total", rises, W + R);
      end else if (cs_n) csbad++;
      // write word feeder
      if (tx_pend) begin
        tx_idx++;
        tx_valid = 1'b0;
        tx_hold  = txd;
        tx_pend  = 1'b0;
      end
      if (!tx_valid && tx_idx < ntx) begin
        if (tx_hold == 0) begin
          tx_valid = 1'b1;
          tx_word  = txw(tx_idx, seed);
        end else tx_hold--;
      end
      if (tx_valid && tx_ready) tx_pend = 1'b1;
      // read word consumer
      if (rx_pend) begin
        rx_pend  = 1'b0;
        rx_ready = (rxd == 0);
        rx_hold  = rxd;
      end else if (rx_valid && !rx_ready) begin
        if (rx_hold == 0) rx_ready = 1'b1;
        else rx_hold--;
      end
      if (rx_valid && rx_ready) begin
        chk(rx_word == rxw(rx_idx, seed), "R5", "received word", rx_word, rxw(rx_idx, seed));
        rx_idx++;
        rx_pend = 1'b1;
      end
      cyc++;
      @(negedge clk);
    end
    if (!finished) begin
      hung = 1'b1;
      chk(1'b0, "R9", "watchdog expired", guard, 0);
    end
    tx_valid = 1'b0;
    dev_en   = 1'b0;
    chk(tx_idx == ntx, "R2", "write words taken", tx_idx, ntx);
    chk(rx_idx == nrx, "R5", "read words delivered", rx_idx, nrx);
    chk(csbad == 0, "R10", "cycles with cs_n high mid-transaction", csbad, 0);
    chk(!tx_ready, "R7", "tx_ready low when idle", tx_ready, 0);
  endtask

  initial begin
    int cw[5];
    int cr[5];
    int idx;
    cw[0] = 32; cr[0] = 32;
    cw[1] = 64; cr[1] = 32;
    cw[2] = 32; cr[2] = 96;
    cw[3] = 40; cr[3] = 40;
    cw[4] = 1;  cr[4] = 1;
    repeat (3) @(negedge clk);
    chk(cs_n && !sclk && sdio_oe && !sdio_o, "R1", "bus pins at reset",
        {cs_n, sclk, sdio_oe, sdio_o}, 4'b1010);
    chk(!busy && !tx_ready && !rx_valid && !done_pulse, "R1", "status at reset",
        {busy, tx_ready, rx_valid, done_pulse}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(cs_n && !sclk && sdio_oe && !sdio_o && !busy, "R1", "idle after reset release",
        {cs_n, sclk, sdio_oe, sdio_o, busy}, 5'b10100);
    for (int hd = 1; hd <= 3 && !hung; hd++) begin
      for (int ci = 0; ci < 5 && !hung; ci++) begin
        idx = hd * 5 + ci;
        run_txn(hd, cw[ci], cr[ci], idx % 3, (idx % 2) * 3, idx % 4, idx);
      end
    end
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule